// File: doc/BRIEF.md
# Cascadable 4-bit magnitude comparator, chained to 8 bits

This block compares two unsigned operands and raises exactly one of three flags: operand A greater, operands equal, or operand A less. It is built from identical 4-bit comparator slices. Each slice has three cascade inputs that carry the verdict of the next less significant slice. When a slice's own nibbles differ, that slice decides the result alone. When they match, it passes the lower-order verdict through unchanged.

The top level chains two slices into an 8-bit comparator. The slice on bits 3..0 is the low-order stage. Its cascade inputs are fixed to "equal", which means the equal input is high and the other two are low. The low-order stage's three outputs drive the cascade inputs of the slice on bits 7..4, and that slice's outputs are the block's outputs. The block is purely combinational and has no clock.

Top module: `cmp_chain8`

## Requirements
- R1: For every pair of 8-bit operands, exactly one of `a_gt_o`, `a_eq_o`, `a_lt_o` is 1.
- R2: `a_gt_o` is 1 exactly when `a_i` is greater than `b_i` as unsigned numbers.
- R3: `a_eq_o` is 1 exactly when every one of the 8 bit pairs of `a_i` and `b_i` matches.
- R4: `a_lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned numbers.
- R5: When bits 7..4 of `a_i` and `b_i` differ, the outputs follow the comparison of bits 7..4 alone, whatever bits 3..0 hold.
- R6: When bits 7..4 of `a_i` and `b_i` are equal, the outputs are the comparison of bits 3..0.
- R7: A difference in any single bit position, from bit 0 up to bit 7, clears `a_eq_o`.
- R8: Bit 7 is the most significant bit with positive weight. For example, 0x80 compares greater than 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| a_gt_o | output | 1 | A greater than B |
| a_eq_o | output | 1 | A equal to B |
| a_lt_o | output | 1 | A less than B |

## Verification
A table of directed pairs covers four cases:
- High nibbles that differ while the low nibbles point the other way. These show whether the upper slice overrides the cascade.
- Equal high nibbles. These show whether the lower verdict is passed through.
- Operands that differ in one bit only. These show whether every bit-equality term reaches the equal flag.
- The 0x80 against 0x7F pair. This shows unsigned bit weighting.

An exhaustive sweep of all 65,536 operand pairs is then checked against an arithmetic model, and each pair is checked for one-hot outputs. The sweep separates a design that is right on typical values from one that is right everywhere.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Three-way verdict carried between slices
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_res_t;

  // Verdict fed to the least significant slice: operands so far are equal
  localparam cmp_res_t RES_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/cmp_bit_eq.sv
module cmp_bit_eq #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] match_o
);

  // One XNOR per bit pair
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign match_o[gi] = ~(a_i[gi] ^ b_i[gi]);
  end

endmodule

// File: rtl/cmp_mag.sv
module cmp_mag #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] match_i,
  output logic         a_big_o,
  output logic         all_eq_o
);

  logic found;

  // The most significant mismatching bit decides; A is bigger if its bit is 1 there
  always_comb begin
    found   = 1'b0;
    a_big_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && !match_i[i]) begin
        found   = 1'b1;
        a_big_o = a_i[i];
      end
    end
  end

  assign all_eq_o = &match_i;

endmodule

// File: rtl/cmp_slice.sv
module cmp_slice
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_res_t     cas_i,
  output cmp_res_t     res_o
);

  logic [W-1:0] match;
  logic         a_big;
  logic         all_eq;

  cmp_bit_eq #(.W(W)) u_eq (
    .a_i     (a_i),
    .b_i     (b_i),
    .match_o (match)
  );

  cmp_mag #(.W(W)) u_mag (
    .a_i      (a_i),
    .match_i  (match),
    .a_big_o  (a_big),
    .all_eq_o (all_eq)
  );

  // Local nibbles equal: lower verdict passes; otherwise local verdict wins
  always_comb begin
    if (all_eq) begin
      res_o = cas_i;
    end else begin
      res_o.gt = a_big;
      res_o.eq = 1'b0;
      res_o.lt = ~a_big;
    end
  end

endmodule

// File: rtl/cmp_chain8.sv
module cmp_chain8
  import cmp_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2
) (
  input  logic [SLICE_W*N_SLICES-1:0] a_i,
  input  logic [SLICE_W*N_SLICES-1:0] b_i,
  output logic                        a_gt_o,
  output logic                        a_eq_o,
  output logic                        a_lt_o
);

  localparam int TOT_W = SLICE_W * N_SLICES;

  // link[k] is the verdict entering slice k; link[N_SLICES] is the final one
  cmp_res_t link [N_SLICES+1];

  assign link[0] = RES_SEED;

  for (genvar gs = 0; gs < N_SLICES; gs++) begin : g_slice
    cmp_slice #(.W(SLICE_W)) u_slice (
      .a_i   (a_i[gs*SLICE_W +: SLICE_W]),
      .b_i   (b_i[gs*SLICE_W +: SLICE_W]),
      .cas_i (link[gs]),
      .res_o (link[gs+1])
    );
  end

  assign a_gt_o = link[N_SLICES].gt;
  assign a_eq_o = link[N_SLICES].eq;
  assign a_lt_o = link[N_SLICES].lt;

endmodule

// File: rtl/cmp_chain8_chk.sv
module cmp_chain8_chk #(
  parameter int TOT_W   = 8,
  parameter int SLICE_W = 4
) (
  input logic [TOT_W-1:0] a_i,
  input logic [TOT_W-1:0] b_i,
  input logic             a_gt_o,
  input logic             a_eq_o,
  input logic             a_lt_o
);

  localparam int LO_W = TOT_W - SLICE_W;

  logic [SLICE_W-1:0] a_hi, b_hi;
  logic [LO_W-1:0]    a_lo, b_lo;

  assign a_hi = a_i[TOT_W-1 -: SLICE_W];
  assign b_hi = b_i[TOT_W-1 -: SLICE_W];
  assign a_lo = a_i[LO_W-1:0];
  assign b_lo = b_i[LO_W-1:0];

  always_comb begin
    // R1
    one_hot_chk: assert ($countones({a_gt_o, a_eq_o, a_lt_o}) == 1);
    // R2
    gt_match_chk: assert (a_gt_o == (a_i > b_i));
    // R3
    eq_match_chk: assert (a_eq_o == (a_i == b_i));
    // R4
    lt_match_chk: assert (a_lt_o == (a_i < b_i));
    // R5
    hi_decides_chk: assert ((a_hi == b_hi) || (a_gt_o == (a_hi > b_hi)));
    // R6
    lo_passes_chk: assert ((a_hi != b_hi) ||
                           ({a_gt_o, a_lt_o} == {a_lo > b_lo, a_lo < b_lo}));
  end

endmodule

bind cmp_chain8 cmp_chain8_chk #(.TOT_W(TOT_W), .SLICE_W(SLICE_W)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .a_gt_o (a_gt_o),
  .a_eq_o (a_eq_o),
  .a_lt_o (a_lt_o)
);

// File: tb/sim_cmp_chain8.sv
`timescale 1ns/1ps
module sim_cmp_chain8;

  logic       clk;
  logic       rst_n;
  logic [7:0] a, b;
  logic       gt, eq, lt;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  cmp_chain8 u0 (
    .a_i    (a),
    .b_i    (b),
    .a_gt_o (gt),
    .a_eq_o (eq),
    .a_lt_o (lt)
  );

  // {a, b, expected gt, eq, lt}
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {8'h00, 8'h00, 3'b010},  // R3 all zero
    {8'hFF, 8'hFF, 3'b010},  // R3 all one
    {8'h80, 8'h7F, 3'b100},  // R8 bit 7 weight
    {8'h7F, 8'h80, 3'b001},  // R8 reverse
    {8'h35, 8'h34, 3'b100},  // R6 low decides
    {8'h34, 8'h35, 3'b001},  // R6 low decides
    {8'h4F, 8'h50, 3'b001},  // R5 high overrides low
    {8'h50, 8'h4F, 3'b100},  // R5 high overrides low
    {8'h01, 8'h00, 3'b100},  // R2
    {8'h00, 8'h01, 3'b001},  // R4
    {8'hA5, 8'hA4, 3'b100},  // R7 bit 0 only
    {8'hA5, 8'h25, 3'b100},  // R7 bit 7 only
    {8'hF0, 8'h0F, 3'b100},  // R5
    {8'h0F, 8'hF0, 3'b001},  // R5
    {8'h9C, 8'h9C, 3'b010},  // R6 equal passes
    {8'h96, 8'h9E, 3'b001}   // R7 bit 3 only
  };

  task automatic check3(string tag, logic [2:0] exp);
    checks++;
    if ({gt, eq, lt} !== exp) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h actual=%b expected=%b", tag, a, b, {gt, eq, lt}, exp);
    end
  endtask

  task automatic check_hot(string tag);
    checks++;
    if ($countones({gt, eq, lt}) != 1) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h actual=%b expected=one-hot", tag, a, b, {gt, eq, lt});
    end
  endtask

  task automatic apply(logic [7:0] va, logic [7:0] vb);
    @(posedge clk);
    a = va;
    b = vb;
    @(negedge clk);
  endtask

  function automatic logic [2:0] model(logic [7:0] va, logic [7:0] vb);
    return {va > vb, va == vb, va < vb};
  endfunction

  // Watchdog
  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = 8'h00;
    b = 8'h00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Initial state: zero operands give equal (R3)
    check3("R3", 3'b010);

    // Directed table (R2..R8)
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][18:11], VEC[i][10:3]);
      if (VEC[i][18:15] != VEC[i][10:7])
        check3("R5", VEC[i][2:0]);
      else
        check3("R6", VEC[i][2:0]);
    end

    // Single-bit differences at every position clear equality (R7)
    for (int k = 0; k < 8; k++) begin
      apply(8'h5A ^ (8'h01 << k), 8'h5A);
      check3("R7", model(8'h5A ^ (8'h01 << k), 8'h5A));
    end

    // Exhaustive sweep (R1, R2, R3, R4)
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        apply(ia[7:0], ib[7:0]);
        check_hot("R1");
        if (ia > ib)       check3("R2", model(ia[7:0], ib[7:0]));
        else if (ia == ib) check3("R3", model(ia[7:0], ib[7:0]));
        else               check3("R4", model(ia[7:0], ib[7:0]));
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule